// File: doc/BRIEF.md
# Zero-Address Stack Expression Engine

This block executes zero-address arithmetic on an internal register stack. Four instructions exist. PUSH and POP name a word address in an external data memory. ADD and MUL name nothing; they always consume the two entries nearest the top of the stack and leave one result in their place. A host presents one instruction at a time on a valid/ready handshake. The engine pulses `done` when the instruction has finished. An expression such as (A+B)*(C+D) is therefore evaluated by the sequence PUSH A, PUSH B, ADD, PUSH C, PUSH D, ADD, MUL, POP X.

The stack holds `DEPTH` entries of `DW` bits. Its fill level is visible on `depth`. Illegal requests set a sticky `err` flag and leave the stack untouched. These are a push onto a full stack, an arithmetic operation with fewer than two operands, and a pop from an empty stack. Such a request still completes with a `done` pulse. The data memory has a single port with a read latency of one cycle: `mem_rdata` is valid in the cycle after `mem_rd_en`.

The controller is a state machine with six states:
- S_IDLE: ready for an instruction.
- S_READ: memory read issued.
- S_LOAD: read data pushed onto the stack.
- S_WRITE: top entry written to memory and removed.
- S_EXEC: the arithmetic result replaces the top two entries.
- S_FINISH: the `done` pulse.

Its transitions are:
- S_IDLE to S_READ on an accepted PUSH when the stack is not full.
- S_IDLE to S_WRITE on an accepted POP when the stack is not empty.
- S_IDLE to S_EXEC on an accepted ADD or MUL when the stack holds at least two entries.
- S_IDLE to S_FINISH on any faulting instruction.
- S_READ to S_LOAD.
- S_LOAD, S_WRITE and S_EXEC to S_FINISH.
- S_FINISH back to S_IDLE.

Top module: `zstack_engine`

## Requirements
- R1: `instr_ready` is high only while the engine is idle. An instruction is accepted on a rising edge where `instr_valid` and `instr_ready` are both high. `instr_ready` stays low until the cycle after the `done` pulse. The opcode field `instr_op` encodes PUSH=2'b00, POP=2'b01, ADD=2'b10, MUL=2'b11.
- R2: A PUSH on a non-full stack issues exactly one `mem_rd_en` pulse to `instr_addr` and places the returned word on a new top of stack, raising `depth` by one. `done` is high in the third cycle after acceptance.
- R3: A POP on a non-empty stack issues exactly one `mem_wr_en` pulse that writes the top entry to `instr_addr`, then removes that entry. `done` is high in the second cycle after acceptance.
- R4: ADD replaces the top two entries with their sum modulo 2^DW. `depth` drops by one, no memory access occurs, and `done` is high in the second cycle after acceptance.
- R5: MUL replaces the top two entries with the low DW bits of their product. `depth` drops by one and no memory access occurs.
- R6: A PUSH while `depth` equals DEPTH sets `err`, issues no memory read and leaves all stack contents unchanged. `depth` never exceeds DEPTH.
- R7: ADD or MUL with fewer than two entries sets `err` and leaves `depth` and the stack contents unchanged.
- R8: A POP on an empty stack sets `err` and performs no memory write.
- R9: Once set, `err` stays high until reset.
- R10: `done` is a single-cycle pulse. For a faulting instruction it is high in the first cycle after acceptance.
- R11: After reset, `depth` is 0, `err` is 0, `done` is 0, `instr_ready` is 1, and neither memory strobe is active.
- R12: The sequence PUSH A, PUSH B, ADD, PUSH C, PUSH D, ADD, MUL, POP X stores (A+B)*(C+D), truncated to DW bits, at X and leaves `depth` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction offered |
| instr_op | input | 2 | Opcode: 00 PUSH, 01 POP, 10 ADD, 11 MUL |
| instr_addr | input | AW | Memory word address for PUSH/POP |
| instr_ready | output | 1 | Engine idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky fault flag |
| depth | output | $clog2(DEPTH+1) | Number of entries on the stack |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_rd_en` |

## Verification
The bench fills the stack to capacity and then pushes once more. A design that compared against the wrong limit would either read memory and overwrite an entry, or refuse the eighth push. The stack is then drained, so that any overwrite shows up as a wrong value in last-in-first-out order.

Arithmetic is run on operands that wrap: 0xFFFF+2, and a product larger than 16 bits. Operand-order or truncation mistakes show up in the value that is popped afterwards. Underflow is tested with ADD on an empty stack, MUL on a one-entry stack and POP on an empty stack. A design that let any of these through would change `depth`, corrupt the remaining entry or produce a stray write strobe. Completion latencies are measured per instruction, so an extra or missing state in any path is visible.

// File: rtl/zstk_pkg.sv
package zstk_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_ADD  = 2'b10,
        OP_MUL  = 2'b11
    } zop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_LOAD,
        S_WRITE,
        S_EXEC,
        S_FINISH
    } zstate_e;

endpackage

// File: rtl/zstk_alu.sv
module zstk_alu #(
    parameter int DW = 16
) (
    input  logic          mul_sel,
    input  logic [DW-1:0] opnd_top,
    input  logic [DW-1:0] opnd_next,
    output logic [DW-1:0] result
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] product;

    always_comb begin
        product = PW'(opnd_next) * PW'(opnd_top);
        if (mul_sel) begin
            result = product[DW-1:0];
        end else begin
            result = opnd_next + opnd_top;
        end
    end
endmodule

// File: rtl/zstk_store.sv
module zstk_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [DW-1:0] push_data,
    input  logic          pop_en,
    input  logic          reduce_en,
    input  logic [DW-1:0] reduce_data,
    output logic [CW-1:0] depth,
    output logic [DW-1:0] top_val,
    output logic [DW-1:0] next_val
);
    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       idx_top;
    logic [CW-1:0]       idx_next;
    logic [DEPTH*DW-1:0] flat;

    assign idx_top  = cnt_q - CW'(1);
    assign idx_next = cnt_q - CW'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push_en) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop_en || reduce_en) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (push_en && cnt_q == CW'(g)) begin
                q <= push_data;
            end else if (reduce_en && idx_next == CW'(g)) begin
                q <= reduce_data;
            end
        end
        assign flat[g*DW +: DW] = q;
    end

    always_comb begin
        top_val  = '0;
        next_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx_top == CW'(i)) begin
                top_val = flat[i*DW +: DW];
            end
            if (idx_next == CW'(i)) begin
                next_val = flat[i*DW +: DW];
            end
        end
    end

    assign depth = cnt_q;
endmodule

// File: rtl/zstk_ctrl.sv
module zstk_ctrl
    import zstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [1:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    input  logic [CW-1:0] depth,
    output logic          instr_ready,
    output logic          done,
    output logic          err,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic          push_en,
    output logic          pop_en,
    output logic          reduce_en,
    output logic          mul_sel
);
    zstate_e       state_q, state_d;
    zop_e          op_q;
    logic [AW-1:0] addr_q;
    logic          err_q;
    logic          accept;
    logic          fault;
    logic          is_full;
    logic          is_empty;
    logic          has_two;

    assign accept   = instr_valid && (state_q == S_IDLE);
    assign is_full  = (depth == CW'(DEPTH));
    assign is_empty = (depth == '0);
    assign has_two  = (depth >= CW'(2));

    always_comb begin
        fault = 1'b0;
        if (accept) begin
            unique case (zop_e'(instr_op))
                OP_PUSH:        fault = is_full;
                OP_POP:         fault = is_empty;
                OP_ADD, OP_MUL: fault = !has_two;
                default:        fault = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (fault) begin
                        state_d = S_FINISH;
                    end else begin
                        unique case (zop_e'(instr_op))
                            OP_PUSH:        state_d = S_READ;
                            OP_POP:         state_d = S_WRITE;
                            OP_ADD, OP_MUL: state_d = S_EXEC;
                            default:        state_d = S_FINISH;
                        endcase
                    end
                end
            end
            S_READ:   state_d = S_LOAD;
            S_LOAD:   state_d = S_FINISH;
            S_WRITE:  state_d = S_FINISH;
            S_EXEC:   state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_PUSH;
            addr_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_q | fault;
            if (accept) begin
                op_q   <= zop_e'(instr_op);
                addr_q <= instr_addr;
            end
        end
    end

    always_comb begin
        instr_ready = (state_q == S_IDLE);
        mem_rd_en   = (state_q == S_READ);
        push_en     = (state_q == S_LOAD);
        mem_wr_en   = (state_q == S_WRITE);
        pop_en      = (state_q == S_WRITE);
        reduce_en   = (state_q == S_EXEC);
        done        = (state_q == S_FINISH);
        mul_sel     = (op_q == OP_MUL);
        mem_addr    = addr_q;
        err         = err_q;
    end
endmodule

// File: rtl/zstack_engine.sv
module zstack_engine #(
    parameter int DW    = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [1:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    output logic          instr_ready,
    output logic          done,
    output logic          err,
    output logic [CW-1:0] depth,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic          push_en;
    logic          pop_en;
    logic          reduce_en;
    logic          mul_sel;
    logic [DW-1:0] top_val;
    logic [DW-1:0] next_val;
    logic [DW-1:0] alu_out;

    zstk_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .instr_addr  (instr_addr),
        .depth       (depth),
        .instr_ready (instr_ready),
        .done        (done),
        .err         (err),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .mem_addr    (mem_addr),
        .push_en     (push_en),
        .pop_en      (pop_en),
        .reduce_en   (reduce_en),
        .mul_sel     (mul_sel)
    );

    zstk_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_en     (push_en),
        .push_data   (mem_rdata),
        .pop_en      (pop_en),
        .reduce_en   (reduce_en),
        .reduce_data (alu_out),
        .depth       (depth),
        .top_val     (top_val),
        .next_val    (next_val)
    );

    zstk_alu #(.DW(DW)) u_alu (
        .mul_sel   (mul_sel),
        .opnd_top  (top_val),
        .opnd_next (next_val),
        .result    (alu_out)
    );

    assign mem_wdata = top_val;
endmodule

// File: rtl/zstk_checker.sv
module zstk_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic          instr_ready,
    input logic [1:0]    instr_op,
    input logic          done,
    input logic          err,
    input logic [CW-1:0] depth,
    input logic          mem_rd_en,
    input logic          mem_wr_en
);
    logic take;
    assign take = instr_valid && instr_ready;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> (!done && !mem_rd_en && !mem_wr_en));

    p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (depth == $past(depth) - CW'(1)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    p_full_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b00 && depth == CW'(DEPTH)) |=> (err && done && !mem_rd_en && $stable(depth)));

    p_short_operands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op[1] && depth < CW'(2)) |=> (err && done && $stable(depth)));

    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && instr_op == 2'b01 && depth == '0) |=> (err && !mem_wr_en));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_strobes_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
endmodule

bind zstack_engine zstk_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_op    (instr_op),
    .done        (done),
    .err         (err),
    .depth       (depth),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en)
);

// File: tb/zstack_engine_tb.sv
`timescale 1ns/1ps
module zstack_engine_tb;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    localparam logic [1:0] PUSH = 2'b00;
    localparam logic [1:0] POP  = 2'b01;
    localparam logic [1:0] ADD  = 2'b10;
    localparam logic [1:0] MUL  = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [1:0]    instr_op = 2'b00;
    logic [AW-1:0] instr_addr = '0;
    logic          instr_ready, done, err, mem_rd_en, mem_wr_en;
    logic [CW-1:0] depth;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] dmem [1 << AW];
    int n_chk = 0;
    int n_fail = 0;
    int n_rd = 0;
    int n_wr = 0;

    always #2 clk = ~clk;

    zstack_engine #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_addr(instr_addr), .instr_ready(instr_ready), .done(done), .err(err),
        .depth(depth), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_wr_en) dmem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= dmem[mem_addr];
    end

    always @(negedge clk) begin
        if (mem_rd_en) n_rd <= n_rd + 1;
        if (mem_wr_en) n_wr <= n_wr + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [AW-1:0] a, output int lat);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_addr  = a;
        while (!instr_ready) @(negedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        chk(!done, "R10", "done width", int'(done), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(depth == 0, "R11", "depth", int'(depth), 0);
        chk(err == 0, "R11", "err", int'(err), 0);
        chk(done == 0, "R11", "done", int'(done), 0);
        chk(instr_ready == 1, "R11", "ready", int'(instr_ready), 1);
        chk(!mem_rd_en && !mem_wr_en, "R11", "strobes", int'({mem_rd_en, mem_wr_en}), 0);
    endtask

    task automatic t_program();
        int lat;
        int r0;
        int w0;
        dmem[10] = 16'd3; dmem[11] = 16'd5; dmem[12] = 16'd7; dmem[13] = 16'd2; dmem[20] = 16'h0;
        r0 = n_rd;
        w0 = n_wr;
        run(PUSH, 8'd10, lat);
        chk(lat == 3, "R2", "push latency", lat, 3);
        chk(n_rd == r0 + 1, "R2", "read pulses", n_rd - r0, 1);
        chk(depth == 1, "R2", "depth after push", int'(depth), 1);
        run(PUSH, 8'd11, lat);
        run(ADD, 8'd0, lat);
        chk(lat == 2, "R4", "add latency", lat, 2);
        chk(depth == 1, "R4", "depth after add", int'(depth), 1);
        run(PUSH, 8'd12, lat);
        run(PUSH, 8'd13, lat);
        run(ADD, 8'd0, lat);
        run(MUL, 8'd0, lat);
        chk(lat == 2, "R5", "mul latency", lat, 2);
        chk(n_wr == w0, "R4", "no writes during arithmetic", n_wr - w0, 0);
        chk(n_rd == r0 + 4, "R5", "reads total", n_rd - r0, 4);
        run(POP, 8'd20, lat);
        chk(lat == 2, "R3", "pop latency", lat, 2);
        chk(n_wr == w0 + 1, "R3", "write pulses", n_wr - w0, 1);
        chk(dmem[20] == 16'd72, "R12", "result at X", int'(dmem[20]), 72);
        chk(depth == 0, "R12", "final depth", int'(depth), 0);
        chk(err == 0, "R12", "err clear", int'(err), 0);
    endtask

    task automatic t_wrap();
        int lat;
        dmem[30] = 16'hFFFF; dmem[31] = 16'h0002; dmem[32] = 16'h1234; dmem[33] = 16'h0100;
        run(PUSH, 8'd30, lat);
        run(PUSH, 8'd31, lat);
        run(ADD, 8'd0, lat);
        run(POP, 8'd40, lat);
        chk(dmem[40] == 16'h0001, "R4", "wrapped sum", int'(dmem[40]), 1);
        run(PUSH, 8'd32, lat);
        run(PUSH, 8'd33, lat);
        run(MUL, 8'd0, lat);
        run(POP, 8'd41, lat);
        chk(dmem[41] == 16'h3400, "R5", "truncated product", int'(dmem[41]), 32'h3400);
        chk(depth == 0, "R3", "depth after pops", int'(depth), 0);
    endtask

    task automatic t_overflow();
        int lat;
        int r0;
        for (int i = 0; i < DEPTH + 1; i++) dmem[50 + i] = 16'(100 + i);
        for (int i = 0; i < DEPTH; i++) run(PUSH, 8'(50 + i), lat);
        chk(depth == CW'(DEPTH), "R6", "full depth", int'(depth), DEPTH);
        chk(err == 0, "R6", "no err at capacity", int'(err), 0);
        r0 = n_rd;
        run(PUSH, 8'(50 + DEPTH), lat);
        chk(lat == 1, "R10", "fault latency", lat, 1);
        chk(err == 1, "R6", "err on overflow", int'(err), 1);
        chk(n_rd == r0, "R6", "no read on overflow", n_rd - r0, 0);
        chk(depth == CW'(DEPTH), "R6", "depth held", int'(depth), DEPTH);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            run(POP, 8'(80 + i), lat);
            chk(dmem[80 + i] == 16'(100 + i), "R6", "LIFO contents intact", int'(dmem[80 + i]), 100 + i);
        end
        chk(err == 1, "R9", "err sticky", int'(err), 1);
    endtask

    task automatic t_underflow();
        int lat;
        int w0;
        do_reset();
        chk(err == 0, "R9", "reset clears err", int'(err), 0);
        run(ADD, 8'd0, lat);
        chk(err == 1, "R7", "err on add empty", int'(err), 1);
        chk(depth == 0, "R7", "depth held on empty add", int'(depth), 0);
        dmem[60] = 16'd77;
        run(PUSH, 8'd60, lat);
        run(MUL, 8'd0, lat);
        chk(lat == 1, "R7", "short mul latency", lat, 1);
        chk(depth == 1, "R7", "depth held on short mul", int'(depth), 1);
        run(POP, 8'd61, lat);
        chk(dmem[61] == 16'd77, "R7", "entry intact", int'(dmem[61]), 77);
        w0 = n_wr;
        dmem[62] = 16'hABCD;
        run(POP, 8'd62, lat);
        chk(n_wr == w0, "R8", "no write on empty pop", n_wr - w0, 0);
        chk(dmem[62] == 16'hABCD, "R8", "target unchanged", int'(dmem[62]), 32'hABCD);
        chk(err == 1, "R8", "err on empty pop", int'(err), 1);
        chk(depth == 0, "R8", "depth stays zero", int'(depth), 0);
    endtask

    task automatic t_handshake();
        int lat;
        dmem[70] = 16'd9;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op = PUSH;
        instr_addr = 8'd70;
        @(negedge clk);
        chk(instr_ready == 0, "R1", "ready low while busy", int'(instr_ready), 0);
        instr_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        chk(instr_ready == 1, "R1", "ready back after done", int'(instr_ready), 1);
        chk(depth == 1, "R1", "one instruction accepted", int'(depth), 1);
        run(POP, 8'd71, lat);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) dmem[i] = '0;
        mem_rdata = '0;
        t_reset_state();
        t_program();
        t_wrap();
        t_handshake();
        t_overflow();
        t_underflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule